// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Arbitration

This block is a clocked memory of 2048 words by 8 bits with two fully independent access ports, called port 0 and port 1. Each port has its own active-low select, an active-low write strobe (high means read), an active-low output enable, an address, write data and a busy signal. Either port may read or write any location at any time. Reads are registered: the word selected in one cycle appears on the read data output after the next rising edge, together with a valid flag.

When both ports are selected on the same address in the same cycle, a small arbitration state machine decides which port owns the location. The port that was already active on that address in the previous cycle keeps ownership. If both arrive in the same cycle, port 0 is chosen. The losing port sees its busy output driven low in that same cycle. A losing port cannot write, and while the owner writes, the loser's read output holds its last value. Busy is released as soon as the addresses differ or either select goes high.

For stacking several devices to make a wider word, a slave mode turns busy into an input. The busy outputs stay high, and each port's writes are blocked while its busy input is low. In this way one master device arbitrates for all the slices.

The arbitration state machine has three states. ARB_FREE means no port owns a contended address. ARB_P0_OWNS means port 0 won the current collision, and ARB_P1_OWNS means port 1 won it. The transitions are named as follows. CLAIM goes from ARB_FREE to an owner state when a match appears: the port seen on that address in the previous cycle wins, and a tie goes to port 0. KEEP stays in an owner state while the match continues and the owner is still on the same address. REARB re-decides as in CLAIM when a match continues but the owner has moved to a new address. RELEASE goes from any state back to ARB_FREE when no match exists.

Top module: `dpram_arbiter`

## Requirements
- R1: A word written through either port at any address from 0 to 2047 is returned by a later read on either port. The read data and a high valid flag appear after the rising edge that ends the read cycle.
- R2: A location changes only in a cycle in which the writing port has both select and write strobe low. A cycle with the write strobe low and the select high leaves memory unchanged.
- R3: A match means both selects are low and the addresses are equal. When a match exists, exactly one port has busy low in that same cycle, and the other port has busy high.
- R4: If a port was selected on the matching address in the previous cycle and the other port was not, the earlier port wins and the other port gets busy.
- R5: If both ports begin a matching access in the same cycle, port 0 wins and port 1 gets busy.
- R6: Busy returns high in the same cycle in which the addresses differ or either select goes high.
- R7: In master mode a write by the port that has busy low does not change memory.
- R8: In slave mode (slave_mode high) both busy outputs stay high. A port's write is suppressed while its busy input is low and takes effect while its busy input is high.
- R9: While a port is blocked and the other port writes, the blocked port's read data does not change. After the block ends, the next read edge returns the newly stored word.
- R10: When both ports read the same location under collision, both receive the stored word.
- R11: After reset both read data outputs are 0, both valid flags are 0 and both busy outputs are high.
- R12: The read valid flag is high after a read edge only if output enable was low in that read cycle.
- R13: Writes from both ports to different addresses in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | High: busy acts as an input that blocks writes |
| p0_cs_n | input | 1 | Port 0 select, active low |
| p0_we_n | input | 1 | Port 0 write strobe, low writes, high reads |
| p0_oe_n | input | 1 | Port 0 output enable, active low |
| p0_addr | input | 11 | Port 0 address |
| p0_wdata | input | 8 | Port 0 write data |
| p0_busy_in_n | input | 1 | Port 0 busy input used in slave mode |
| p0_busy_n | output | 1 | Port 0 busy, low when port 0 lost a collision |
| p0_rdata | output | 8 | Port 0 registered read data |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p1_cs_n | input | 1 | Port 1 select, active low |
| p1_we_n | input | 1 | Port 1 write strobe, low writes, high reads |
| p1_oe_n | input | 1 | Port 1 output enable, active low |
| p1_addr | input | 11 | Port 1 address |
| p1_wdata | input | 8 | Port 1 write data |
| p1_busy_in_n | input | 1 | Port 1 busy input used in slave mode |
| p1_busy_n | output | 1 | Port 1 busy, low when port 1 lost a collision |
| p1_rdata | output | 8 | Port 1 registered read data |
| p1_rvalid | output | 1 | Port 1 read data valid |

## Verification
A wrong ownership state shows up in the same cycle as a match. Either the wrong busy output goes low, or both go low, or the port that should have kept the location loses it. A stale owner after a release shows up as a busy that stays low after the addresses part. If the write gating is wrong, the loser's data reaches memory, which a read on the next free cycle reveals. A broken hold shows up as the loser's read data changing at the first edge during the owner's write, instead of only after busy rises.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        ARB_FREE    = 2'd0,
        ARB_P0_OWNS = 2'd1,
        ARB_P1_OWNS = 2'd2
    } arb_state_t;

endpackage

// File: rtl/dpram_collision_fsm.sv
module dpram_collision_fsm
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cs_n,
    input  logic [1:0][ADDR_W-1:0] addr,
    output logic [1:0]             lose
);

    arb_state_t             state_q;
    arb_state_t             state_d;
    logic [1:0]             prev_act_q;
    logic [1:0][ADDR_W-1:0] prev_addr_q;
    logic                   match;
    logic [1:0]             seen;
    logic                   fresh_win1;

    assign match = !cs_n[0] && !cs_n[1] && (addr[0] == addr[1]);

    for (genvar i = 0; i < 2; i++) begin : g_seen
        assign seen[i] = prev_act_q[i] && (prev_addr_q[i] == addr[i]);
    end

    // fresh decision: port 1 only when it alone was already here
    assign fresh_win1 = seen[1] && !seen[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ARB_FREE;
            prev_act_q  <= '0;
            prev_addr_q <= '0;
        end else begin
            state_q     <= state_d;
            prev_act_q  <= ~cs_n;
            prev_addr_q <= addr;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = ARB_FREE;
        lose    = 2'b00;
        unique case (state_q)
            ARB_FREE: begin
                if (match) begin
                    state_d = fresh_win1 ? ARB_P1_OWNS : ARB_P0_OWNS;
                end
            end
            ARB_P0_OWNS: begin
                if (match && seen[0]) begin
                    state_d = ARB_P0_OWNS;
                end else if (match) begin
                    state_d = fresh_win1 ? ARB_P1_OWNS : ARB_P0_OWNS;
                end
            end
            ARB_P1_OWNS: begin
                if (match && seen[1]) begin
                    state_d = ARB_P1_OWNS;
                end else if (match) begin
                    state_d = fresh_win1 ? ARB_P1_OWNS : ARB_P0_OWNS;
                end
            end
            default: begin
                state_d = ARB_FREE;
            end
        endcase
        if (state_d == ARB_P0_OWNS) lose[1] = 1'b1;
        if (state_d == ARB_P1_OWNS) lose[0] = 1'b1;
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic [1:0]             wr_en,
    input  logic [1:0][ADDR_W-1:0] addr,
    input  logic [1:0][DATA_W-1:0] wdata,
    output logic [1:0][DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // port 1 first so port 0 prevails on an equal address
    always_ff @(posedge clk) begin
        if (wr_en[1]) cells[addr[1]] <= wdata[1];
        if (wr_en[0]) cells[addr[0]] <= wdata[0];
    end

    for (genvar i = 0; i < 2; i++) begin : g_rd
        assign rdata[i] = cells[addr[i]];
    end

endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              blocked,
    input  logic              other_wr,
    input  logic [DATA_W-1:0] cell_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic read_req;
    logic hold;

    assign read_req = !cs_n && we_n;
    assign wr_en    = !cs_n && !we_n && !blocked;
    assign hold     = blocked && other_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= read_req && !oe_n;
            if (read_req && !hold) begin
                rdata <= cell_data;
            end
        end
    end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              p0_cs_n,
    input  logic              p0_we_n,
    input  logic              p0_oe_n,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    input  logic              p0_busy_in_n,
    output logic              p0_busy_n,
    output logic [DATA_W-1:0] p0_rdata,
    output logic              p0_rvalid,
    input  logic              p1_cs_n,
    input  logic              p1_we_n,
    input  logic              p1_oe_n,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    input  logic              p1_busy_in_n,
    output logic              p1_busy_n,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              p1_rvalid
);

    logic [1:0]             cs_n;
    logic [1:0]             we_n;
    logic [1:0]             oe_n;
    logic [1:0][ADDR_W-1:0] addr;
    logic [1:0][DATA_W-1:0] wdata;
    logic [1:0]             busy_in_n;
    logic [1:0]             lose;
    logic [1:0]             blocked;
    logic [1:0]             wr_en;
    logic [1:0][DATA_W-1:0] cell_data;
    logic [1:0][DATA_W-1:0] rdata;
    logic [1:0]             rvalid;

    assign cs_n      = {p1_cs_n, p0_cs_n};
    assign we_n      = {p1_we_n, p0_we_n};
    assign oe_n      = {p1_oe_n, p0_oe_n};
    assign addr      = {p1_addr, p0_addr};
    assign wdata     = {p1_wdata, p0_wdata};
    assign busy_in_n = {p1_busy_in_n, p0_busy_in_n};

    dpram_collision_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (cs_n),
        .addr (addr),
        .lose (lose)
    );

    dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(cell_data)
    );

    for (genvar i = 0; i < 2; i++) begin : g_port
        assign blocked[i] = slave_mode ? !busy_in_n[i] : lose[i];

        dpram_port_ctl #(.DATA_W(DATA_W)) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .cs_n     (cs_n[i]),
            .we_n     (we_n[i]),
            .oe_n     (oe_n[i]),
            .blocked  (blocked[i]),
            .other_wr (wr_en[1-i]),
            .cell_data(cell_data[i]),
            .wr_en    (wr_en[i]),
            .rdata    (rdata[i]),
            .rvalid   (rvalid[i])
        );
    end

    assign p0_busy_n = slave_mode || !lose[0];
    assign p1_busy_n = slave_mode || !lose[1];
    assign p0_rdata  = rdata[0];
    assign p1_rdata  = rdata[1];
    assign p0_rvalid = rvalid[0];
    assign p1_rvalid = rvalid[1];

endmodule

// File: rtl/dpram_arbiter_chk.sv
module dpram_arbiter_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              p0_cs_n,
    input logic              p0_we_n,
    input logic [ADDR_W-1:0] p0_addr,
    input logic              p0_busy_n,
    input logic [DATA_W-1:0] p0_rdata,
    input logic              p1_cs_n,
    input logic              p1_we_n,
    input logic [ADDR_W-1:0] p1_addr,
    input logic              p1_busy_n,
    input logic [DATA_W-1:0] p1_rdata
);

    logic match;
    assign match = !p0_cs_n && !p1_cs_n && (p0_addr == p1_addr);

    assert_busy_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!p0_busy_n && !p1_busy_n));

    assert_one_busy_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && match) |-> (p0_busy_n != p1_busy_n));

    assert_no_match_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (p0_busy_n && p1_busy_n));

    assert_keep_owner_p0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && match && !p1_busy_n) |=>
        (!(match && !slave_mode && $stable(p0_addr) && $stable(p1_addr)) || !p1_busy_n));

    assert_keep_owner_p1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && match && !p0_busy_n) |=>
        (!(match && !slave_mode && $stable(p0_addr) && $stable(p1_addr)) || !p0_busy_n));

    assert_hold_p1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !p1_busy_n && !p0_cs_n && !p0_we_n) |=> $stable(p1_rdata));

    assert_hold_p0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !p0_busy_n && !p1_cs_n && !p1_we_n) |=> $stable(p0_rdata));

    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (p0_busy_n && p1_busy_n));

endmodule

bind dpram_arbiter dpram_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_mode(slave_mode),
    .p0_cs_n   (p0_cs_n),
    .p0_we_n   (p0_we_n),
    .p0_addr   (p0_addr),
    .p0_busy_n (p0_busy_n),
    .p0_rdata  (p0_rdata),
    .p1_cs_n   (p1_cs_n),
    .p1_we_n   (p1_we_n),
    .p1_addr   (p1_addr),
    .p1_busy_n (p1_busy_n),
    .p1_rdata  (p1_rdata)
);

// File: tb/sim_dpram_arbiter.sv
`timescale 1ns/1ps
module sim_dpram_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slave_mode = 1'b0;
    logic        p0_cs_n = 1'b1, p0_we_n = 1'b1, p0_oe_n = 1'b1, p0_busy_in_n = 1'b1;
    logic [10:0] p0_addr = '0;
    logic [7:0]  p0_wdata = '0;
    logic        p1_cs_n = 1'b1, p1_we_n = 1'b1, p1_oe_n = 1'b1, p1_busy_in_n = 1'b1;
    logic [10:0] p1_addr = '0;
    logic [7:0]  p1_wdata = '0;
    logic        p0_busy_n, p1_busy_n, p0_rvalid, p1_rvalid;
    logic [7:0]  p0_rdata, p1_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    dpram_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .p0_cs_n(p0_cs_n), .p0_we_n(p0_we_n), .p0_oe_n(p0_oe_n),
        .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_busy_in_n(p0_busy_in_n),
        .p0_busy_n(p0_busy_n), .p0_rdata(p0_rdata), .p0_rvalid(p0_rvalid),
        .p1_cs_n(p1_cs_n), .p1_we_n(p1_we_n), .p1_oe_n(p1_oe_n),
        .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_busy_in_n(p1_busy_in_n),
        .p1_busy_n(p1_busy_n), .p1_rdata(p1_rdata), .p1_rvalid(p1_rvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int p, input bit cs, input bit we, input bit oe,
                         input logic [10:0] a, input logic [7:0] d);
        if (p == 0) begin
            p0_cs_n = cs; p0_we_n = we; p0_oe_n = oe; p0_addr = a; p0_wdata = d;
        end else begin
            p1_cs_n = cs; p1_we_n = we; p1_oe_n = oe; p1_addr = a; p1_wdata = d;
        end
    endtask

    task automatic release_all();
        drive(0, 1, 1, 1, '0, '0);
        drive(1, 1, 1, 1, '0, '0);
    endtask

    task automatic wr(input int p, input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); drive(p, 0, 0, 1, a, d);
        @(negedge clk); drive(p, 1, 1, 1, a, d);
    endtask

    task automatic rd(input int p, input logic [10:0] a, input bit oe,
                      output logic [7:0] d, output logic v);
        @(negedge clk); drive(p, 0, 1, oe, a, '0);
        @(posedge clk); #1;
        d = (p == 0) ? p0_rdata : p1_rdata;
        v = (p == 0) ? p0_rvalid : p1_rvalid;
        @(negedge clk); drive(p, 1, 1, 1, a, '0);
    endtask

    task automatic t_reset();
        chk("R11 p0_rdata", p0_rdata, 0);
        chk("R11 p1_rdata", p1_rdata, 0);
        chk("R11 p0_rvalid", p0_rvalid, 0);
        chk("R11 p1_rvalid", p1_rvalid, 0);
        chk("R11 p0_busy_n", p0_busy_n, 1);
        chk("R11 p1_busy_n", p1_busy_n, 1);
    endtask

    task automatic t_basic_R1();
        logic [7:0] d; logic v;
        wr(0, 11'd0, 8'hA5);
        wr(1, 11'd2047, 8'h3C);
        rd(1, 11'd0, 0, d, v);
        chk("R1 p1 reads addr 0", d, 8'hA5);
        chk("R1 p1 rvalid", v, 1);
        rd(0, 11'd2047, 0, d, v);
        chk("R1 p0 reads addr 2047", d, 8'h3C);
        chk("R1 p0 rvalid", v, 1);
    endtask

    task automatic t_write_gate_R2();
        logic [7:0] d; logic v;
        wr(0, 11'd5, 8'h11);
        @(negedge clk); drive(0, 1, 0, 1, 11'd5, 8'hFF);
        @(negedge clk); drive(0, 1, 1, 1, 11'd5, 8'h00);
        rd(1, 11'd5, 0, d, v);
        chk("R2 deselected write ignored", d, 8'h11);
    endtask

    task automatic t_oe_R12();
        logic [7:0] d; logic v;
        rd(0, 11'd5, 1, d, v);
        chk("R12 rvalid low with oe high", v, 0);
        rd(0, 11'd5, 0, d, v);
        chk("R12 rvalid high with oe low", v, 1);
    endtask

    task automatic t_tie_R5();
        wr(0, 11'd10, 8'h5A);
        wr(0, 11'd11, 8'h6B);
        @(negedge clk);
        drive(0, 0, 1, 0, 11'd10, '0);
        drive(1, 0, 1, 0, 11'd10, '0);
        #1;
        chk("R5 tie p0_busy_n", p0_busy_n, 1);
        chk("R5 tie p1_busy_n", p1_busy_n, 0);
        @(posedge clk); #1;
        chk("R10 p0 shared read", p0_rdata, 8'h5A);
        chk("R10 p1 shared read", p1_rdata, 8'h5A);
        @(negedge clk);
        drive(1, 0, 1, 0, 11'd11, '0);
        #1;
        chk("R6 addr change frees p1", p1_busy_n, 1);
        @(posedge clk); #1;
        chk("R1 p1 reads new addr", p1_rdata, 8'h6B);
        @(negedge clk); release_all();
    endtask

    task automatic t_first_wins_R4();
        wr(0, 11'd20, 8'h20);
        @(negedge clk); drive(1, 0, 1, 0, 11'd20, '0);
        @(negedge clk); drive(0, 0, 1, 0, 11'd20, '0);
        #1;
        chk("R4 late p0 busy", p0_busy_n, 0);
        chk("R4 early p1 free", p1_busy_n, 1);
        @(negedge clk); #1;
        chk("R4 ownership kept", p0_busy_n, 0);
        drive(1, 1, 1, 1, 11'd20, '0);
        #1;
        chk("R6 winner deselect frees p0", p0_busy_n, 1);
        @(negedge clk); release_all();
    endtask

    task automatic t_loser_write_R7();
        logic [7:0] d; logic v;
        wr(0, 11'd40, 8'h12);
        @(negedge clk); drive(0, 0, 1, 0, 11'd40, '0);
        @(negedge clk); drive(1, 0, 0, 1, 11'd40, 8'h99);
        #1;
        chk("R4 reader p0 keeps owner", p0_busy_n, 1);
        chk("R3 writer p1 busy", p1_busy_n, 0);
        @(negedge clk); release_all();
        rd(1, 11'd40, 0, d, v);
        chk("R7 loser write suppressed", d, 8'h12);
    endtask

    task automatic t_hold_R9();
        logic [7:0] d; logic v;
        wr(0, 11'd30, 8'h55);
        wr(1, 11'd31, 8'h66);
        rd(1, 11'd31, 0, d, v);
        chk("R1 p1 preload read", d, 8'h66);
        @(negedge clk);
        drive(0, 0, 0, 1, 11'd30, 8'h77);
        drive(1, 0, 1, 0, 11'd30, '0);
        #1;
        chk("R3 reader p1 busy", p1_busy_n, 0);
        @(posedge clk); #1;
        chk("R9 p1 held edge 1", p1_rdata, 8'h66);
        @(negedge clk); drive(0, 0, 0, 1, 11'd30, 8'h78);
        @(posedge clk); #1;
        chk("R9 p1 held edge 2", p1_rdata, 8'h66);
        @(negedge clk); drive(0, 1, 1, 1, 11'd30, '0);
        #1;
        chk("R6 p1 released", p1_busy_n, 1);
        @(posedge clk); #1;
        chk("R9 p1 updates after release", p1_rdata, 8'h78);
        @(negedge clk); release_all();
    endtask

    task automatic t_dual_write_R13();
        logic [7:0] d; logic v;
        @(negedge clk);
        drive(0, 0, 0, 1, 11'd100, 8'hC1);
        drive(1, 0, 0, 1, 11'd200, 8'hD2);
        #1;
        chk("R13 no busy p0", p0_busy_n, 1);
        chk("R13 no busy p1", p1_busy_n, 1);
        @(negedge clk); release_all();
        rd(1, 11'd100, 0, d, v);
        chk("R13 p0 write landed", d, 8'hC1);
        rd(0, 11'd200, 0, d, v);
        chk("R13 p1 write landed", d, 8'hD2);
    endtask

    task automatic t_slave_R8();
        logic [7:0] d; logic v;
        wr(0, 11'd50, 8'h21);
        @(negedge clk);
        slave_mode = 1'b1;
        drive(0, 0, 1, 0, 11'd10, '0);
        drive(1, 0, 1, 0, 11'd10, '0);
        #1;
        chk("R8 slave p0 busy high", p0_busy_n, 1);
        chk("R8 slave p1 busy high", p1_busy_n, 1);
        @(negedge clk); release_all();
        p0_busy_in_n = 1'b0;
        wr(0, 11'd50, 8'hAA);
        p0_busy_in_n = 1'b1;
        rd(1, 11'd50, 0, d, v);
        chk("R8 write blocked by busy input", d, 8'h21);
        wr(0, 11'd50, 8'hBB);
        rd(1, 11'd50, 0, d, v);
        chk("R8 write passes with busy input high", d, 8'hBB);
        @(negedge clk); slave_mode = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic_R1();
        t_write_gate_R2();
        t_oe_R12();
        t_tie_R5();
        t_first_wins_R4();
        t_loser_write_R7();
        t_hold_R9();
        t_dual_write_R13();
        t_slave_R8();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule